// File: doc/BRIEF.md
# Programmable Video Line Buffer Chain

This block lines up pixels from consecutive video lines so that a vertical filter can work on one column at a time. A registered input stage captures each incoming sample. Behind it sit seven equal delay lines in a row, each holding one line's worth of samples. The input register and the seven delay-line outputs form eight taps. At any instant these taps hold the same horizontal position from eight successive lines.

The line length is programmed through a configuration value. The delay of each line is that value plus four, and values above the legal ceiling are treated as the ceiling. A recirculate control makes every delay line feed on its own output, so a stored line can be played back as often as needed. A broadcast control sends the input register to all seven delay lines at once, which fills the whole chain in the time of one line. An active-low shift enable freezes the whole chain. A cascade control shortens only the first delay line by two samples. This allows for the two extra register stages that sit in front of a downstream copy of the block.

Top module: `vline_tap_chain`

## Requirements
- R1: After reset is released and before the first shifting edge, all eight taps read zero.
- R2: Tap 0 is the input register. On a rising edge with `shift_en_n` low it takes `din`, so it shows the sample presented one cycle earlier.
- R3: In delay mode (`recirc` and `bcast_load` low) tap k+1 equals the value tap k held L shifts earlier, with L = `len_cfg` + 4, once the delay lines have been filled.
- R4: L reaches its minimum of 4 at `len_cfg` = 0 and its maximum of 3076 at `len_cfg` = 3072.
- R5: Any `len_cfg` above 3072 behaves exactly as 3072. Moving between such a value and 3072 is not a length change.
- R6: With `recirc` high, every delay line writes back its own output, so each of taps 1 to 7 repeats with period L and `din` has no effect on them.
- R7: With `bcast_load` high and `recirc` low, every delay line is fed from tap 0, so each of taps 1 to 7 equals tap 0 delayed by that line's length.
- R8: With `shift_en_n` high, the input register and all delay lines keep their contents, and all taps stay unchanged.
- R9: With `casc_mode` high, the first delay line (tap 1 against tap 0) has delay L − 2. The other six keep delay L.
- R10: A change of the effective length or of `casc_mode` restarts every line pointer at zero. After L further shifts, the affected lines again follow R3, R7 or R9.
- R11: When `recirc` and `bcast_load` are both high, recirculation takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en_n | input | 1 | Low: advance input register and delay lines; high: hold |
| din | input | DATA_W (12) | Incoming sample |
| len_cfg | input | CFG_W (12) | Line length minus four; clamped to CFG_MAX |
| recirc | input | 1 | Each delay line feeds on its own output |
| bcast_load | input | 1 | All delay lines fed from the input register |
| casc_mode | input | 1 | Shorten the first delay line by two |
| taps | output | (NUM_BUF+1)*DATA_W (96) | Tap t in bits [t*DATA_W +: DATA_W]; tap 0 is the input register |

## Verification
A corrupted line pointer or ring length shows up at the taps as a misalignment between neighbouring taps. It appears at most one line length after the fault. A missed restart on a length change leaves taps shifted by a fixed offset, and this stays visible for every later shift. A wrong source choice (chain, broadcast or self) is visible on the tap behind the affected line as soon as the first sample written under that choice comes back out, which is L shifts later. Stray movement during a hold is visible on the very next cycle.

// File: rtl/vlb_pkg.sv
package vlb_pkg;

  localparam int DEF_DATA_W    = 12;
  localparam int DEF_CFG_W     = 12;
  localparam int DEF_CFG_MAX   = 3072;
  localparam int DEF_LEN_BIAS  = 4;
  localparam int DEF_CASC_TRIM = 2;
  localparam int DEF_NUM_BUF   = 7;

  typedef enum logic [1:0] {
    SRC_CHAIN = 2'd0,
    SRC_BCAST = 2'd1,
    SRC_SELF  = 2'd2
  } vlb_src_e;

  // configuration value limited to the legal ceiling
  function automatic int clamp_cfg(int cfg, int cfg_max);
    return (cfg > cfg_max) ? cfg_max : cfg;
  endfunction

  // line delay in shifts
  function automatic int line_len(int cfg_c, int bias);
    return cfg_c + bias;
  endfunction

  // ring depth in use: one stage of the delay is the read register
  function automatic int ring_len(int len, bit trim, int trim_amt);
    return trim ? (len - 1 - trim_amt) : (len - 1);
  endfunction

  // recirculation wins over broadcast, broadcast over chaining
  function automatic vlb_src_e pick_src(logic self_fb, logic bcast);
    if (self_fb) return SRC_SELF;
    if (bcast)   return SRC_BCAST;
    return SRC_CHAIN;
  endfunction

endpackage

// File: rtl/vlb_cfg.sv
module vlb_cfg
  import vlb_pkg::*;
#(
  parameter int CFG_W     = DEF_CFG_W,
  parameter int CFG_MAX   = DEF_CFG_MAX,
  parameter int LEN_BIAS  = DEF_LEN_BIAS,
  parameter int CASC_TRIM = DEF_CASC_TRIM,
  parameter int LEN_W     = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] len_cfg,
  input  logic             casc_mode,
  output logic             cfg_chg,
  output logic [LEN_W-1:0] rlen_head,
  output logic [LEN_W-1:0] rlen_body
);

  logic [CFG_W-1:0] cfg_clamped;
  logic [CFG_W-1:0] cfg_q;
  logic             casc_q;

  assign cfg_clamped = CFG_W'(clamp_cfg(int'(len_cfg), CFG_MAX));
  assign cfg_chg     = (cfg_clamped != cfg_q) || (casc_mode != casc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      casc_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_clamped;
      casc_q <= casc_mode;
    end
  end

  assign rlen_body = LEN_W'(ring_len(line_len(int'(cfg_q), LEN_BIAS), 1'b0, CASC_TRIM));
  assign rlen_head = LEN_W'(ring_len(line_len(int'(cfg_q), LEN_BIAS), casc_q, CASC_TRIM));

endmodule

// File: rtl/vlb_ring.sv
module vlb_ring #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 3075,
  parameter int PTR_W  = 12,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              restart,
  input  logic [LEN_W-1:0]  rlen,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_q,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              wrap_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr;
  logic [LEN_W-1:0]  ptr_nx;

  assign ptr_nx = LEN_W'(ptr) + LEN_W'(1);
  assign wrap_o = (ptr_nx >= rlen);
  assign ptr_o  = ptr;

  // storage: one write per shift at the shared pointer
  always_ff @(posedge clk) begin
    if (adv) mem[ptr] <= wr_data;
  end

  // read register and pointer; the read sees the value before this edge's write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      rd_q <= '0;
    end else begin
      if (adv) rd_q <= mem[ptr];
      if (restart)     ptr <= '0;
      else if (adv)    ptr <= wrap_o ? '0 : ptr + PTR_W'(1);
    end
  end

endmodule

// File: rtl/vline_tap_chain.sv
module vline_tap_chain
  import vlb_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int CFG_W     = DEF_CFG_W,
  parameter int CFG_MAX   = DEF_CFG_MAX,
  parameter int LEN_BIAS  = DEF_LEN_BIAS,
  parameter int CASC_TRIM = DEF_CASC_TRIM,
  parameter int NUM_BUF   = DEF_NUM_BUF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          shift_en_n,
  input  logic [DATA_W-1:0]             din,
  input  logic [CFG_W-1:0]              len_cfg,
  input  logic                          recirc,
  input  logic                          bcast_load,
  input  logic                          casc_mode,
  output logic [(NUM_BUF+1)*DATA_W-1:0] taps
);

  localparam int NUM_TAP = NUM_BUF + 1;
  localparam int MAX_LEN = CFG_MAX + LEN_BIAS;
  localparam int DEPTH   = MAX_LEN - 1;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int LEN_W   = PTR_W + 1;

  // named internal events
  logic              shift_adv;
  logic              cfg_chg;
  logic [LEN_W-1:0]  rlen_head;
  logic [LEN_W-1:0]  rlen_body;
  vlb_src_e          src_sel;

  logic [DATA_W-1:0] tap_w     [NUM_TAP];
  logic [DATA_W-1:0] ring_in   [NUM_BUF];
  logic [PTR_W-1:0]  ring_ptr  [NUM_BUF];
  logic [LEN_W-1:0]  ring_len  [NUM_BUF];
  logic              ring_wrap [NUM_BUF];
  logic [DATA_W-1:0] in_q;

  assign shift_adv = !shift_en_n;
  assign src_sel   = pick_src(recirc, bcast_load);

  vlb_cfg #(
    .CFG_W    (CFG_W),
    .CFG_MAX  (CFG_MAX),
    .LEN_BIAS (LEN_BIAS),
    .CASC_TRIM(CASC_TRIM),
    .LEN_W    (LEN_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .len_cfg  (len_cfg),
    .casc_mode(casc_mode),
    .cfg_chg  (cfg_chg),
    .rlen_head(rlen_head),
    .rlen_body(rlen_body)
  );

  // input register: tap 0, no delay line in front of it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_q <= '0;
    else if (shift_adv) in_q <= din;
  end

  assign tap_w[0] = in_q;

  genvar b;
  generate
    for (b = 0; b < NUM_BUF; b++) begin : g_line
      if (b == 0) begin : g_head
        assign ring_len[b] = rlen_head;
      end else begin : g_body
        assign ring_len[b] = rlen_body;
      end

      always_comb begin
        unique case (src_sel)
          SRC_SELF:  ring_in[b] = tap_w[b+1];
          SRC_BCAST: ring_in[b] = tap_w[0];
          default:   ring_in[b] = tap_w[b];
        endcase
      end

      vlb_ring #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .LEN_W (LEN_W)
      ) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (shift_adv),
        .restart(cfg_chg),
        .rlen   (ring_len[b]),
        .wr_data(ring_in[b]),
        .rd_q   (tap_w[b+1]),
        .ptr_o  (ring_ptr[b]),
        .wrap_o (ring_wrap[b])
      );
    end

    for (b = 0; b < NUM_TAP; b++) begin : g_tap
      assign taps[b*DATA_W +: DATA_W] = tap_w[b];
    end
  endgenerate

endmodule

// File: rtl/vline_tap_chain_chk.sv
module vline_tap_chain_chk #(
  parameter int DATA_W  = 12,
  parameter int NUM_TAP = 8,
  parameter int PTR_W   = 12,
  parameter int LEN_W   = 13
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        shift_en_n,
  input logic [DATA_W-1:0]           din,
  input logic [NUM_TAP*DATA_W-1:0]   taps,
  input logic                        cfg_chg,
  input logic [PTR_W-1:0]            ring_ptr0,
  input logic [LEN_W-1:0]            ring_len0,
  input logic                        ring_wrap0
);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_n |=> $stable(taps));

  assert_inreg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_n |=> (taps[DATA_W-1:0] == $past(din)));

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (ring_ptr0 == '0));

  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (LEN_W'(ring_ptr0) < ring_len0));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en_n && !cfg_chg && ring_wrap0) |=> (ring_ptr0 == '0));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en_n && !cfg_chg && !ring_wrap0) |=> (ring_ptr0 == $past(ring_ptr0) + PTR_W'(1)));

endmodule

bind vline_tap_chain vline_tap_chain_chk #(
  .DATA_W (DATA_W),
  .NUM_TAP(NUM_TAP),
  .PTR_W  (PTR_W),
  .LEN_W  (LEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_en_n(shift_en_n),
  .din       (din),
  .taps      (taps),
  .cfg_chg   (cfg_chg),
  .ring_ptr0 (ring_ptr[0]),
  .ring_len0 (ring_len[0]),
  .ring_wrap0(ring_wrap[0])
);

// File: tb/sim_vline_tap_chain.sv
module sim_vline_tap_chain;

  localparam int DW = 12;
  localparam int NB = 7;
  localparam int NT = NB + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          shift_en_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [11:0]   len_cfg = '0;
  logic          recirc = 1'b0;
  logic          bcast_load = 1'b0;
  logic          casc_mode = 1'b0;
  logic [NT*DW-1:0] taps;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;
  string req = "R3";

  always #5 clk = ~clk;

  vline_tap_chain u0 (
    .clk(clk), .rst_n(rst_n), .shift_en_n(shift_en_n), .din(din),
    .len_cfg(len_cfg), .recirc(recirc), .bcast_load(bcast_load),
    .casc_mode(casc_mode), .taps(taps)
  );

  // ---------------- behavioural reference ----------------
  int mq [NB][$];
  int mout [NB];
  int min_r;
  int mkey;

  function automatic int key_of(int cfg, bit cs);
    int c = (cfg > 3072) ? 3072 : cfg;
    return (cs ? 65536 : 0) + c;
  endfunction

  function automatic int stages(int key, int b);
    int L = (key % 65536) + 4;
    if (b == 0 && key >= 65536) return L - 3;
    return L - 1;
  endfunction

  task automatic rebuild();
    for (int b = 0; b < NB; b++) begin
      mq[b].delete();
      for (int k = 0; k < stages(mkey, b); k++) mq[b].push_back(-1);
    end
  endtask

  task automatic model_reset();
    min_r = 0;
    mkey = 0;
    for (int b = 0; b < NB; b++) mout[b] = 0;
    rebuild();
  endtask

  task automatic model_step();
    int k = key_of(int'(len_cfg), casc_mode);
    if (!shift_en_n) begin
      int src [NB];
      for (int b = 0; b < NB; b++)
        src[b] = recirc ? mout[b] : ((bcast_load || b == 0) ? min_r : mout[b-1]);
      for (int b = 0; b < NB; b++) begin
        mout[b] = mq[b].pop_front();
        mq[b].push_back(src[b]);
      end
      min_r = int'(din);
    end
    if (k != mkey) begin
      mkey = k;
      rebuild();
    end
  endtask

  // ---------------- checking ----------------
  function automatic int tap(int t);
    return int'(taps[t*DW +: DW]);
  endfunction

  task automatic chk(string r, int t, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s tap%0d actual %0d expected %0d", r, t, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2", 0, tap(0), min_r);
    for (int b = 0; b < NB; b++)
      if (mout[b] >= 0) chk(req, b + 1, tap(b + 1), mout[b]);
  endtask

  task automatic cyc(bit shn, int d);
    shift_en_n = shn;
    din = DW'(d);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n, int seed);
    for (int i = 0; i < n; i++) cyc(1'b0, (i * 37 + seed * 101 + (i >> 3) * 13) & 12'hFFF);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int snap [NT];
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state visible before any shift
    for (int t = 0; t < NT; t++) chk("R1", t, tap(t), 0);

    // R4 minimum length 4, delay mode
    req = "R4"; len_cfg = 12'd0;
    run(60, 1);

    // R3 with holds interleaved (R8)
    req = "R3"; len_cfg = 12'd5;
    run(80, 2);
    for (int t = 0; t < NT; t++) snap[t] = tap(t);
    req = "R8";
    for (int h = 0; h < 5; h++) begin
      cyc(1'b1, 12'hABC + h);
      for (int t = 0; t < NT; t++) chk("R8", t, tap(t), snap[t]);
    end
    req = "R3";
    for (int i = 0; i < 60; i++) cyc((i % 4) == 3, (i * 53 + 7) & 12'hFFF);

    // R5: out-of-range value acts as 3072; then 3072 itself is no change (R4 max)
    req = "R5"; len_cfg = 12'd4000;
    run(3076 * 7 + 40, 3);
    req = "R4"; len_cfg = 12'd3072;
    run(3100, 4);

    // R6: fill in delay mode, then recirculate
    req = "R10"; len_cfg = 12'd10;
    run(14 * 8, 5);
    req = "R6"; recirc = 1'b1;
    run(30, 6);
    for (int t = 1; t < NT; t++) snap[t] = tap(t);
    run(14, 7);
    for (int t = 1; t < NT; t++) chk("R6", t, tap(t), snap[t]);
    recirc = 1'b0;

    // R7: broadcast load
    req = "R7"; len_cfg = 12'd6; bcast_load = 1'b1;
    run(40, 8);
    // R11: recirculate over broadcast
    req = "R11"; recirc = 1'b1;
    run(30, 9);
    recirc = 1'b0; bcast_load = 1'b0;

    // R9: cascade shortens first line
    req = "R9"; len_cfg = 12'd7; casc_mode = 1'b1;
    run(100, 10);
    req = "R9"; len_cfg = 12'd0;
    run(50, 11);

    // R10: length change mid stream with casc toggled off
    req = "R10"; casc_mode = 1'b0; len_cfg = 12'd3;
    run(70, 12);
    len_cfg = 12'd9;
    run(120, 13);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nerr++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule